// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the register file a processor uses to program a four-channel DMA controller. It sits behind an 8-bit data port with a 4-bit offset. Each channel has a 16-bit start address and a 16-bit transfer count. Both are loaded and read one byte at a time through a single offset. A shared byte-pointer flip-flop selects the low or the high half of whichever 16-bit register is being accessed, and every byte access to the address or count space moves the pointer to the other half. Software clears the pointer once to reach a known state and then tracks it.

Besides the word registers, the block decodes packed control bytes. The first kind sets or clears the mask of one channel, with the channel number in the low two bits. The second kind carries a channel's transfer mode, with the channel number in the same two bits. The block also holds a command byte, a software request latch and sticky terminal-count flags. It provides a master clear. The decoded mask and mode fields, along with the address and count values, go out to the transfer engines. Those engines return terminal-count pulses, pending-request lines and a temporary data byte, and the block reports all three on reads.

Top module: `dma_port_regs`

## Requirements
- R1: After reset all four mask bits are 1, the command byte is 0x00, every address and count is 0x0000, the status byte reads 0x00 and the byte pointer selects the low byte.
- R2: Writing offset 2n (for n = 0..3) loads the address of channel n, and writing offset 2n+1 loads its count. The byte goes to the low half when the pointer is clear and to the high half when it is set.
- R3: Reading offset 2n or 2n+1 returns the low or high byte of that register, as the pointer selects. Every read or write in offsets 0x0..0x7 flips the pointer, so reads and writes share one pointer.
- R4: A write of any value to offset 0xC clears the pointer, so the next word access targets the low byte.
- R5: A write to offset 0xA selects a channel with bits 1:0. Bit 2 = 1 sets that channel's mask, bit 2 = 0 clears it, and the other mask bits are kept.
- R6: A write to offset 0xF loads all four mask bits from data bits 3:0 (bit n for channel n). A write to offset 0xE clears all four.
- R7: A write to offset 0xB stores bits 7:2 as the mode of the channel in bits 1:0. Bits 7:6 drive the mode select (01 single, 11 cascade), bit 5 drives decrement, bit 4 drives auto-initialize and bits 3:2 drive the transfer direction (01 I/O to memory, 10 memory to I/O). Other channels keep their mode.
- R8: A write to offset 0x8 stores the command byte, which appears on `cmdOut`.
- R9: A write to offset 0x9 sets (bit 2 = 1) or clears (bit 2 = 0) the software request of the channel in bits 1:0. Status bits 7:4 read the OR of software requests and `reqIn`, with bit 4+n for channel n.
- R10: A `tcIn` pulse sets the matching flag in status bits 3:0. A read of offset 0x8 returns the flags and then clears them, except that a pulse arriving in the same cycle as the read leaves its flag set.
- R11: A write to offset 0xD is a master clear. It clears the pointer, the command byte, the terminal-count flags and the software requests, and it sets all four mask bits. Addresses, counts and modes are kept.
- R12: A read of offset 0xD returns `tempIn`. Reads of write-only offsets (0x9..0xC, 0xE, 0xF) return 0x00. Neither kind of read moves the pointer, and any access with `cs` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Port select |
| wrEn | input | 1 | Write strobe (takes priority over read) |
| rdEn | input | 1 | Read strobe |
| addr | input | 4 | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle of the read |
| tcIn | input | 4 | Terminal-count pulses from the engines |
| reqIn | input | 4 | Pending hardware requests |
| tempIn | input | 8 | Temporary data byte from the engines |
| chAddr | output | 64 | Address of channel n in bits 16n+15:16n |
| chCount | output | 64 | Count of channel n in bits 16n+15:16n |
| chMask | output | 4 | Per-channel mask, 1 = disabled |
| chModeSel | output | 8 | Mode select of channel n in bits 2n+1:2n |
| chXfer | output | 8 | Transfer direction of channel n in bits 2n+1:2n |
| chAutoInit | output | 4 | Auto-initialize enable per channel |
| chDecr | output | 4 | Address decrement per channel |
| cmdOut | output | 8 | Command byte |

## Verification
Two events can hit the terminal-count flags in the same clock: an engine pulse on `tcIn` and a status read that clears the flags. The bench raises a pulse on channel 2 in the same cycle as a status read. The read must return the flag still clear, and the next status read must show it set and then clear it. A separate pulse followed by two reads checks the normal set-then-clear path.

// File: rtl/dma_port_pkg.sv
package dma_port_pkg;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int WORD_W = 2 * DATA_W;
  localparam int MODE_W = DATA_W - CH_W;

  localparam logic [ADDR_W-1:0] OFS_CMD     = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_REQ     = 4'h9;
  localparam logic [ADDR_W-1:0] OFS_MASK1   = 4'hA;
  localparam logic [ADDR_W-1:0] OFS_MODE    = 4'hB;
  localparam logic [ADDR_W-1:0] OFS_PTRCLR  = 4'hC;
  localparam logic [ADDR_W-1:0] OFS_MCLR    = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_MASKCLR = 4'hE;
  localparam logic [ADDR_W-1:0] OFS_MASKALL = 4'hF;

  typedef enum logic [2:0] {
    RD_NONE, RD_ADDR, RD_COUNT, RD_STATUS, RD_TEMP
  } rdSel_e;

  typedef struct packed {
    logic [NUM_CH-1:0] wrAddr;
    logic [NUM_CH-1:0] wrCount;
    logic              hiByte;
    logic              wrCmd;
    logic              wrReq;
    logic              wrMask1;
    logic              wrMode;
    logic              wrMaskClr;
    logic              wrMaskAll;
    logic              masterClr;
    logic              rdStatus;
    rdSel_e            rdSel;
    logic [CH_W-1:0]   rdCh;
  } strobe_t;
endpackage

// File: rtl/dma_port_ctrl.sv
module dma_port_ctrl
  import dma_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output logic              ptrHi
);
  localparam logic [ADDR_W-1:0] WORD_SPAN = ADDR_W'(2 * NUM_CH);

  logic doWr, doRd, inWordSpace, isCount, ptrClr;
  logic [CH_W-1:0] ch;

  assign doWr        = cs & wrEn;
  assign doRd        = cs & rdEn & ~wrEn;
  assign inWordSpace = (addr < WORD_SPAN);
  assign isCount     = addr[0];
  assign ch          = addr[CH_W:1];
  assign ptrClr      = doWr & (addr == OFS_PTRCLR);

  always_comb begin
    stb        = '0;
    stb.hiByte = ptrHi;
    stb.rdSel  = RD_NONE;
    stb.rdCh   = ch;
    if (doWr) begin
      if (inWordSpace) begin
        stb.wrAddr[ch]  = ~isCount;
        stb.wrCount[ch] = isCount;
      end else begin
        case (addr)
          OFS_CMD:     stb.wrCmd     = 1'b1;
          OFS_REQ:     stb.wrReq     = 1'b1;
          OFS_MASK1:   stb.wrMask1   = 1'b1;
          OFS_MODE:    stb.wrMode    = 1'b1;
          OFS_MCLR:    stb.masterClr = 1'b1;
          OFS_MASKCLR: stb.wrMaskClr = 1'b1;
          OFS_MASKALL: stb.wrMaskAll = 1'b1;
          default: ;
        endcase
      end
    end else if (doRd) begin
      if (inWordSpace) begin
        stb.rdSel = isCount ? RD_COUNT : RD_ADDR;
      end else if (addr == OFS_CMD) begin
        stb.rdSel    = RD_STATUS;
        stb.rdStatus = 1'b1;
      end else if (addr == OFS_MCLR) begin
        stb.rdSel = RD_TEMP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         ptrHi <= 1'b0;
    else if (stb.masterClr || ptrClr)  ptrHi <= 1'b0;
    else if ((doWr || doRd) && inWordSpace) ptrHi <= ~ptrHi;
  end
endmodule

// File: rtl/dma_port_dp.sv
module dma_port_dp
  import dma_port_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]        tcIn,
  input  logic [NUM_CH-1:0]        reqIn,
  input  logic [DATA_W-1:0]        tempIn,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_CH*WORD_W-1:0] chAddr,
  output logic [NUM_CH*WORD_W-1:0] chCount,
  output logic [NUM_CH-1:0]        chMask,
  output logic [NUM_CH*2-1:0]      chModeSel,
  output logic [NUM_CH*2-1:0]      chXfer,
  output logic [NUM_CH-1:0]        chAutoInit,
  output logic [NUM_CH-1:0]        chDecr,
  output logic [DATA_W-1:0]        cmdOut,
  output logic [NUM_CH-1:0]        tcFlags
);
  logic [WORD_W-1:0] addrQ  [NUM_CH];
  logic [WORD_W-1:0] countQ [NUM_CH];
  logic [MODE_W-1:0] modeQ  [NUM_CH];
  logic [NUM_CH-1:0] maskQ, swReqQ;
  logic [CH_W-1:0]   selCh;

  assign selCh = wrData[CH_W-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ[i]  <= '0;
        countQ[i] <= '0;
        modeQ[i]  <= '0;
      end else begin
        if (stb.wrAddr[i]) begin
          if (stb.hiByte) addrQ[i][WORD_W-1:DATA_W] <= wrData;
          else            addrQ[i][DATA_W-1:0]      <= wrData;
        end
        if (stb.wrCount[i]) begin
          if (stb.hiByte) countQ[i][WORD_W-1:DATA_W] <= wrData;
          else            countQ[i][DATA_W-1:0]      <= wrData;
        end
        if (stb.wrMode && (selCh == CH_W'(i)))
          modeQ[i] <= wrData[DATA_W-1:CH_W];
      end
    end
    assign chAddr[i*WORD_W +: WORD_W]  = addrQ[i];
    assign chCount[i*WORD_W +: WORD_W] = countQ[i];
    assign chModeSel[2*i +: 2]         = modeQ[i][5:4];
    assign chDecr[i]                   = modeQ[i][3];
    assign chAutoInit[i]               = modeQ[i][2];
    assign chXfer[2*i +: 2]            = modeQ[i][1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.masterClr) begin
      maskQ   <= '1;
      swReqQ  <= '0;
      cmdOut  <= '0;
      tcFlags <= '0;
    end else begin
      if (stb.wrMaskAll)      maskQ        <= wrData[NUM_CH-1:0];
      else if (stb.wrMaskClr) maskQ        <= '0;
      else if (stb.wrMask1)   maskQ[selCh] <= wrData[2];
      if (stb.wrReq)          swReqQ[selCh] <= wrData[2];
      if (stb.wrCmd)          cmdOut <= wrData;
      tcFlags <= (stb.rdStatus ? '0 : tcFlags) | tcIn;
    end
  end

  assign chMask = maskQ;

  always_comb begin
    case (stb.rdSel)
      RD_ADDR:   rdData = stb.hiByte ? addrQ[stb.rdCh][WORD_W-1:DATA_W]
                                     : addrQ[stb.rdCh][DATA_W-1:0];
      RD_COUNT:  rdData = stb.hiByte ? countQ[stb.rdCh][WORD_W-1:DATA_W]
                                     : countQ[stb.rdCh][DATA_W-1:0];
      RD_STATUS: rdData = {swReqQ | reqIn, tcFlags};
      RD_TEMP:   rdData = tempIn;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_port_regs.sv
module dma_port_regs (
  input  logic                                             clk,
  input  logic                                             rstN,
  input  logic                                             cs,
  input  logic                                             wrEn,
  input  logic                                             rdEn,
  input  logic [dma_port_pkg::ADDR_W-1:0]                  addr,
  input  logic [dma_port_pkg::DATA_W-1:0]                  wrData,
  output logic [dma_port_pkg::DATA_W-1:0]                  rdData,
  input  logic [dma_port_pkg::NUM_CH-1:0]                  tcIn,
  input  logic [dma_port_pkg::NUM_CH-1:0]                  reqIn,
  input  logic [dma_port_pkg::DATA_W-1:0]                  tempIn,
  output logic [dma_port_pkg::NUM_CH*dma_port_pkg::WORD_W-1:0] chAddr,
  output logic [dma_port_pkg::NUM_CH*dma_port_pkg::WORD_W-1:0] chCount,
  output logic [dma_port_pkg::NUM_CH-1:0]                  chMask,
  output logic [dma_port_pkg::NUM_CH*2-1:0]                chModeSel,
  output logic [dma_port_pkg::NUM_CH*2-1:0]                chXfer,
  output logic [dma_port_pkg::NUM_CH-1:0]                  chAutoInit,
  output logic [dma_port_pkg::NUM_CH-1:0]                  chDecr,
  output logic [dma_port_pkg::DATA_W-1:0]                  cmdOut
);
  dma_port_pkg::strobe_t stb;
  logic ptrHi;
  logic [dma_port_pkg::NUM_CH-1:0] tcFlags;

  dma_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cs(cs), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .stb(stb), .ptrHi(ptrHi)
  );

  dma_port_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .tcIn(tcIn),
    .reqIn(reqIn), .tempIn(tempIn), .rdData(rdData), .chAddr(chAddr),
    .chCount(chCount), .chMask(chMask), .chModeSel(chModeSel),
    .chXfer(chXfer), .chAutoInit(chAutoInit), .chDecr(chDecr),
    .cmdOut(cmdOut), .tcFlags(tcFlags)
  );
endmodule

// File: rtl/dma_port_chk.sv
module dma_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cs,
  input logic       wrEn,
  input logic       rdEn,
  input logic [3:0] addr,
  input logic [7:0] wrData,
  input logic [3:0] tcIn,
  input logic [3:0] chMask,
  input logic       ptrHi,
  input logic [3:0] tcFlags
);
  p_ptr_toggle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cs && (wrEn || rdEn) && addr < 4'h8) |=> (ptrHi != $past(ptrHi)));

  p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wrEn && addr == 4'hC) |=> !ptrHi);

  p_mask_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wrEn && addr == 4'hA) |=> (chMask[$past(wrData[1:0])] == $past(wrData[2])));

  p_tc_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((tcIn != 4'h0) && !(cs && wrEn && addr == 4'hD)) |=> ((tcFlags & $past(tcIn)) == $past(tcIn)));

  p_master_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wrEn && addr == 4'hD) |=> (chMask == 4'hF && !ptrHi && tcFlags == 4'h0));

  p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    !cs |=> ($stable(chMask) && $stable(ptrHi)));
endmodule

bind dma_port_regs dma_port_chk u_chk (
  .clk(clk), .rstN(rstN), .cs(cs), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .tcIn(tcIn), .chMask(chMask), .ptrHi(ptrHi), .tcFlags(tcFlags)
);

// File: tb/sim_dma_port_regs.sv
module sim_dma_port_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {isWr, addr, data, expected read, check}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 4'hC, 8'h00, 8'h00, 1'b0},  // R4 pointer clear
    {1'b1, 4'h2, 8'h34, 8'h00, 1'b0},  // R2 ch1 addr low
    {1'b1, 4'h2, 8'h12, 8'h00, 1'b0},  // R2 ch1 addr high
    {1'b0, 4'h2, 8'h00, 8'h34, 1'b1},  // R3 low
    {1'b0, 4'h2, 8'h00, 8'h12, 1'b1},  // R3 high
    {1'b1, 4'h7, 8'hFF, 8'h00, 1'b0},  // R2 ch3 count low
    {1'b0, 4'h7, 8'h00, 8'h00, 1'b1},  // R3 read high after write low
    {1'b1, 4'h7, 8'hAB, 8'h00, 1'b0},  // R3 write lands low again
    {1'b1, 4'hC, 8'h55, 8'h00, 1'b0},  // R4 clear with any value
    {1'b0, 4'h7, 8'h00, 8'hAB, 1'b1},  // R4 low after clear
    {1'b0, 4'h7, 8'h00, 8'h00, 1'b1},  // R3 high
    {1'b0, 4'hD, 8'h00, 8'h5A, 1'b1},  // R12 temp
    {1'b0, 4'hA, 8'h00, 8'h00, 1'b1},  // R12 write-only offset
    {1'b0, 4'h2, 8'h00, 8'h34, 1'b1}   // R12 pointer unmoved
  };

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] addr = '0, tcIn = '0, reqIn = '0;
  logic [7:0] wrData = '0, tempIn = 8'h5A, rdData, cmdOut, lastRd;
  logic [63:0] chAddr, chCount;
  logic [3:0] chMask, chAutoInit, chDecr;
  logic [7:0] chModeSel, chXfer;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_port_regs u0 (
    .clk(clk), .rstN(rstN), .cs(cs), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tcIn(tcIn), .reqIn(reqIn), .tempIn(tempIn),
    .chAddr(chAddr), .chCount(chCount), .chMask(chMask), .chModeSel(chModeSel),
    .chXfer(chXfer), .chAutoInit(chAutoInit), .chDecr(chDecr), .cmdOut(cmdOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic c, input logic w, input logic [3:0] a,
                        input logic [7:0] d, input logic [3:0] tc);
    @(negedge clk);
    cs = c; wrEn = w; rdEn = ~w; addr = a; wrData = d; tcIn = tc;
    #1 lastRd = rdData;
    @(posedge clk);
    #1 cs = 0; wrEn = 0; rdEn = 0; tcIn = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mask", chMask, 4'hF);
    check("R1 cmd", cmdOut, 8'h00);
    check("R1 addr", chAddr, 64'h0);
    access(1, 0, 4'h8, 8'h00, 4'h0);
    check("R1 status", lastRd, 8'h00);

    for (int i = 0; i < NV; i++) begin
      access(1, VEC[i][21], VEC[i][20:17], VEC[i][16:9], 4'h0);
      if (VEC[i][0]) check("R3/R4/R12 vector read", lastRd, VEC[i][8:1]);
    end
    check("R2 ch1 addr", chAddr[31:16], 16'h1234);
    check("R2 ch3 count", chCount[63:48], 16'h00AB);

    // R5 single mask
    access(1, 1, 4'hA, 8'h01, 4'h0);
    check("R5 unmask ch1", chMask, 4'hD);
    access(1, 1, 4'hA, 8'h05, 4'h0);
    check("R5 mask ch1", chMask, 4'hF);
    // R6 all-mask and clear-mask
    access(1, 1, 4'hF, 8'h0A, 4'h0);
    check("R6 mask all", chMask, 4'hA);
    access(1, 1, 4'hE, 8'hFF, 4'h0);
    check("R6 clear mask", chMask, 4'h0);

    // R7 mode
    access(1, 1, 4'hB, 8'h46, 4'h0);
    access(1, 1, 4'hB, 8'h59, 4'h0);
    access(1, 1, 4'hB, 8'hC3, 4'h0);
    check("R7 ch2 mode", {chModeSel[5:4], chDecr[2], chAutoInit[2], chXfer[5:4]}, 6'b01_0_0_01);
    check("R7 ch1 mode", {chModeSel[3:2], chDecr[1], chAutoInit[1], chXfer[3:2]}, 6'b01_0_1_10);
    check("R7 ch3 cascade", chModeSel[7:6], 2'b11);
    check("R7 ch0 untouched", {chModeSel[1:0], chXfer[1:0]}, 4'h0);

    // R8 command
    access(1, 1, 4'h8, 8'h24, 4'h0);
    check("R8 cmd", cmdOut, 8'h24);

    // R9 request
    access(1, 1, 4'h9, 8'h05, 4'h0);
    access(1, 0, 4'h8, 8'h00, 4'h0);
    check("R9 sw request", lastRd, 8'h20);
    reqIn = 4'h8;
    access(1, 1, 4'h9, 8'h01, 4'h0);
    access(1, 0, 4'h8, 8'h00, 4'h0);
    check("R9 hw request only", lastRd, 8'h80);
    reqIn = 4'h0;

    // R10 terminal count
    access(0, 1, 4'h0, 8'h00, 4'h1);
    access(1, 0, 4'h8, 8'h00, 4'h0);
    check("R10 tc set", lastRd, 8'h01);
    access(1, 0, 4'h8, 8'h00, 4'h0);
    check("R10 tc cleared by read", lastRd, 8'h00);
    access(1, 0, 4'h8, 8'h00, 4'h4);
    check("R10 coincident read value", lastRd, 8'h00);
    access(1, 0, 4'h8, 8'h00, 4'h0);
    check("R10 coincident flag kept", lastRd, 8'h04);
    access(1, 0, 4'h8, 8'h00, 4'h0);
    check("R10 flag cleared after", lastRd, 8'h00);

    // R11 master clear
    access(1, 1, 4'hC, 8'h00, 4'h0);
    access(1, 1, 4'h0, 8'h77, 4'h0);
    access(1, 1, 4'h9, 8'h04, 4'h8);
    access(1, 1, 4'hD, 8'h00, 4'h0);
    check("R11 mask set", chMask, 4'hF);
    check("R11 cmd cleared", cmdOut, 8'h00);
    access(1, 0, 4'h8, 8'h00, 4'h0);
    check("R11 status cleared", lastRd, 8'h00);
    access(1, 1, 4'h0, 8'h99, 4'h0);
    check("R11 pointer cleared", chAddr[15:0], 16'h0099);
    check("R11 addr kept", chAddr[31:16], 16'h1234);
    check("R11 mode kept", chXfer[5:4], 2'b01);

    // R12 deselected access
    access(0, 1, 4'hF, 8'h00, 4'h0);
    check("R12 cs low mask", chMask, 4'hF);
    access(0, 1, 4'h0, 8'h11, 4'h0);
    check("R12 cs low addr", chAddr[15:0], 16'h0099);
    access(1, 0, 4'h0, 8'h00, 4'h0);
    check("R12 cs low pointer", lastRd, 8'h00);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule